// File: doc/BRIEF.md
# Synchronous Master Serial Receiver

This block is the receiving side of a serial port that owns the serial clock. It divides the system clock down to a programmable serial clock, drives that clock out and captures one data bit on each falling edge. Captured bits are assembled into 8-bit or 9-bit words. Each finished word is offered to a downstream receive buffer for one cycle through a push interface.

Two enables start reception. The single-word enable stops clocking after one word and reports through a one-cycle clear pulse that the enable is spent. The continuous enable keeps words coming back to back until software drops it. When both are set, continuous operation wins. Dropping the port enable, or both receive enables, returns the receiver to idle at once and discards any partial word.

Top module: `sync_master_rx`

## Requirements
- R1: While reset is asserted, `sclk_out`, `push_valid` and `single_clr` are 0.
- R2: While receiving, `sclk_out` toggles every `divider`+1 system clocks and starts low, so its period is 2×(`divider`+1) clocks. It stays low while the receiver is idle.
- R3: A data bit is taken from `sdata_in` at the system clock edge on which `sclk_out` falls. Bits arrive least significant first, and the first bit is bit 0 of `push_data`.
- R4: With `nine_bit`=0 a word ends after 8 falling edges, and `push_data[8]` is 0.
- R5: With `nine_bit`=1 a word ends after 9 falling edges, and the ninth bit appears on `push_data[8]`.
- R6: With only `single_en` set, exactly one word is received. After that, no further `sclk_out` pulses occur. `single_clr` pulses for one cycle in the cycle after the word's last falling edge.
- R7: With `cont_en` set, words follow each other with no gap until `cont_en` is cleared.
- R8: With both enables set, reception is continuous and `single_clr` never pulses.
- R9: A word is offered in the cycle after its last falling edge. `push_valid` is high then only if `push_ready` is high in that cycle. Otherwise the word is dropped.
- R10: Clearing `port_en`, or clearing both `single_en` and `cont_en`, forces `sclk_out` low by the next clock. It also restarts the bit count, so the next reception begins a fresh word.
- R11: After a single word completes, the receiver stays idle while `single_en` remains high. A new single word needs `single_en` to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Port enable; low forces idle |
| single_en | input | 1 | Receive one word |
| cont_en | input | 1 | Receive continuously (takes precedence) |
| nine_bit | input | 1 | 1 selects 9-bit words, 0 selects 8-bit words |
| divider | input | DIV_W | Half-period of the serial clock minus one, in system clocks |
| sdata_in | input | 1 | Serial data input |
| push_ready | input | 1 | Downstream buffer has room |
| sclk_out | output | 1 | Generated serial clock, idles low |
| push_valid | output | 1 | A finished word is pushed this cycle |
| push_data | output | DATA_W+1 | Finished word, bit 0 received first |
| single_clr | output | 1 | One-cycle pulse telling the host to clear `single_enable` |

## Verification
A wrong divider count or a wrong clock phase shows on `sclk_out` within one half-period. A wrong bit count or a wrong shift direction stays hidden until the word ends, and then shows as a misplaced push or corrupted `push_data`. A stuck completion flag shows as extra clock pulses after a single word, or as a missing `single_clr`. A reset path that fails when the enables drop shows on the next word as misaligned data. The bench therefore compares all outputs against a reference model on every clock, and also checks the words received against the words that were sent.

// File: rtl/srx_pkg.sv
package srx_pkg;
  // word length in bits for the selected mode
  function automatic int unsigned srx_word_len(input logic nine, input int unsigned data_w);
    return nine ? data_w + 1 : data_w;
  endfunction
endpackage

// File: rtl/srx_baud.sv
module srx_baud #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divider,
  output logic             sclk,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sclk_q, sclk_d;
  logic             term;

  always_comb begin
    term      = (cnt_q >= divider);
    cnt_d     = cnt_q;
    sclk_d    = sclk_q;
    fall_tick = 1'b0;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (term) begin
      cnt_d     = '0;
      sclk_d    = ~sclk_q;
      fall_tick = sclk_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  assign sclk = sclk_q;
endmodule

// File: rtl/srx_ctrl.sv
module srx_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic port_en,
  input  logic single_en,
  input  logic cont_en,
  input  logic word_last,
  output logic run,
  output logic single_clr
);
  logic done_q, done_d;
  logic clr_q, clr_d;

  // continuous enable overrides the single-word stop
  assign run = port_en & (cont_en | (single_en & ~done_q));

  always_comb begin
    done_d = done_q;
    if (!port_en || !single_en) begin
      done_d = 1'b0;
    end else if (word_last && !cont_en) begin
      done_d = 1'b1;
    end
    clr_d = word_last & ~cont_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      clr_q  <= clr_d;
    end
  end

  assign single_clr = clr_q;
endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          sample,
  input  logic          sdata,
  input  logic          nine,
  output logic          word_last,
  output logic          word_rdy,
  output logic [DATA_W:0] word
);
  localparam int unsigned SH_W  = DATA_W + 1;
  localparam int unsigned CNT_W = $clog2(SH_W + 1);

  logic [CNT_W-1:0] bits_q, bits_d;
  logic [SH_W-1:0]  sh_q, sh_d, sh_next;
  logic [SH_W-1:0]  word_q, word_d;
  logic             rdy_q;
  logic [CNT_W-1:0] last_idx;

  always_comb begin
    last_idx  = nine ? CNT_W'(SH_W - 1) : CNT_W'(DATA_W - 1);
    sh_next   = {sdata, sh_q[SH_W-1:1]};
    word_last = sample && (bits_q == last_idx);
    bits_d    = bits_q;
    sh_d      = sh_q;
    word_d    = word_q;
    if (!run) begin
      bits_d = '0;
    end else if (sample) begin
      sh_d   = sh_next;
      bits_d = word_last ? '0 : bits_q + 1'b1;
      if (word_last) begin
        word_d = nine ? sh_next : {1'b0, sh_next[SH_W-1:1]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      sh_q   <= '0;
      word_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      bits_q <= bits_d;
      sh_q   <= sh_d;
      word_q <= word_d;
      rdy_q  <= word_last;
    end
  end

  assign word_rdy = rdy_q;
  assign word     = word_q;
endmodule

// File: rtl/sync_master_rx.sv
module sync_master_rx #(
  parameter int unsigned DIV_W  = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_en,
  input  logic             single_en,
  input  logic             cont_en,
  input  logic             nine_bit,
  input  logic [DIV_W-1:0] divider,
  input  logic             sdata_in,
  input  logic             push_ready,
  output logic             sclk_out,
  output logic             push_valid,
  output logic [DATA_W:0]  push_data,
  output logic             single_clr
);
  logic run;
  logic fall_tick;
  logic word_last;
  logic word_rdy;

  srx_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .port_en    (port_en),
    .single_en  (single_en),
    .cont_en    (cont_en),
    .word_last  (word_last),
    .run        (run),
    .single_clr (single_clr)
  );

  srx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .divider   (divider),
    .sclk      (sclk_out),
    .fall_tick (fall_tick)
  );

  srx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .sample    (fall_tick),
    .sdata     (sdata_in),
    .nine      (nine_bit),
    .word_last (word_last),
    .word_rdy  (word_rdy),
    .word      (push_data)
  );

  assign push_valid = word_rdy & push_ready;
endmodule

// File: rtl/srx_checker.sv
module srx_checker (
  input logic clk,
  input logic rst_n,
  input logic port_en,
  input logic single_en,
  input logic cont_en,
  input logic push_ready,
  input logic sclk_out,
  input logic push_valid,
  input logic single_clr,
  input logic word_rdy
);
  p_push_needs_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> push_ready);

  p_clr_with_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    single_clr |-> word_rdy);

  p_cont_blocks_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_en && $past(cont_en)) |-> !single_clr);

  p_port_off_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> !sclk_out);

  p_enables_off_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!single_en && !cont_en) |=> !sclk_out);
endmodule

bind sync_master_rx srx_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .port_en    (port_en),
  .single_en  (single_en),
  .cont_en    (cont_en),
  .push_ready (push_ready),
  .sclk_out   (sclk_out),
  .push_valid (push_valid),
  .single_clr (single_clr),
  .word_rdy   (word_rdy)
);

// File: tb/test_sync_master_rx.sv
module test_sync_master_rx;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       port_en, single_en, cont_en, nine_bit, sdata_in, push_ready;
  logic [7:0] divider;
  logic       sclk_out, push_valid, single_clr;
  logic [8:0] push_data;

  sync_master_rx i_sync_master_rx (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .single_en(single_en),
    .cont_en(cont_en), .nine_bit(nine_bit), .divider(divider),
    .sdata_in(sdata_in), .push_ready(push_ready), .sclk_out(sclk_out),
    .push_valid(push_valid), .push_data(push_data), .single_clr(single_clr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  string tag = "R1";
  bit    tx_q[$];
  int    got[$];
  int    rise_at[$];
  int    clr_cnt = 0, rise_cnt = 0;
  bit    sclk_seen = 0;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference model, updated at each rising edge
  int       m_div, m_bits;
  bit       m_sclk, m_done, m_rdy, m_clr;
  bit [8:0] m_sh, m_word;
  always @(posedge clk) begin
    bit run, last;
    int nb;
    last = 0;
    if (!rst_n) begin
      m_div = 0; m_bits = 0; m_sclk = 0; m_done = 0; m_rdy = 0; m_clr = 0; m_sh = 0;
    end else begin
      nb  = nine_bit ? 9 : 8;
      run = port_en && (cont_en || (single_en && !m_done));
      if (!run) begin
        m_div = 0; m_sclk = 0; m_bits = 0; m_sh = 0;
      end else if (m_div >= int'(divider)) begin
        m_div = 0;
        if (m_sclk) begin
          m_sh[m_bits] = sdata_in;
          m_bits++;
          if (m_bits == nb) begin
            last = 1; m_word = m_sh; m_bits = 0; m_sh = 0;
          end
        end
        m_sclk = !m_sclk;
      end else begin
        m_div++;
      end
      if (!port_en || !single_en) m_done = 0;
      else if (last && !cont_en) m_done = 1;
      m_rdy = last;
      m_clr = last && !cont_en;
    end
  end

  // per-cycle comparison away from the edge
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      check(!sclk_out && !push_valid && !single_clr, "R1", "outputs in reset",
            {sclk_out, push_valid, single_clr}, 0);
    end else begin
      check(sclk_out == m_sclk, tag, "sclk_out", sclk_out, m_sclk);
      check(single_clr == m_clr, tag, "single_clr", single_clr, m_clr);
      check(push_valid == (m_rdy && push_ready), tag, "push_valid", push_valid, m_rdy && push_ready);
      if (push_valid && m_rdy) check(push_data == m_word, tag, "push_data", push_data, m_word);
      if (push_valid) got.push_back(int'(push_data));
      if (single_clr) clr_cnt++;
      if (sclk_out && !sclk_seen) begin rise_cnt++; rise_at.push_back(cyc); end
      sclk_seen = sclk_out;
    end
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send(input int val, input int nb);
    for (int i = 0; i < nb; i++) tx_q.push_back(bit'((val >> i) & 1));
  endtask

  task automatic wait_words(input int n, input int limit);
    for (int i = 0; i < limit && got.size() < n; i++) tick(1);
  endtask

  initial begin
    bit prev;
    rst_n = 0; port_en = 0; single_en = 0; cont_en = 0; nine_bit = 0;
    divider = 8'd2; sdata_in = 0; push_ready = 1;
    // serial data source: advance one bit after each falling serial edge
    fork
      forever begin
        @(posedge clk); #1;
        if (prev && !sclk_out && tx_q.size() > 0) void'(tx_q.pop_front());
        prev = sclk_out;
        sdata_in = (tx_q.size() > 0) ? tx_q[0] : 1'b0;
      end
    join_none
    tick(4);
    rst_n = 1;
    tick(3);

    // single word, 8-bit, divider 2
    tag = "R6"; got.delete(); rise_at.delete(); clr_cnt = 0;
    send(8'hA5, 8);
    port_en = 1; single_en = 1;
    wait_words(1, 300);
    tick(2);
    check(got.size() == 1 && got[0] == 9'h0A5, "R3", "single word data", got.size() ? got[0] : -1, 9'h0A5);
    check(got[0][8] == 0, "R4", "bit 8 in 8-bit mode", got[0][8], 0);
    check(clr_cnt == 1, "R6", "single_clr pulses", clr_cnt, 1);
    check(rise_at.size() >= 2 && rise_at[1] - rise_at[0] == 6, "R2", "serial clock period",
          rise_at.size() >= 2 ? rise_at[1] - rise_at[0] : -1, 6);
    rise_cnt = 0; tag = "R11";
    tick(60);
    check(rise_cnt == 0, "R11", "pulses while single_en held", rise_cnt, 0);
    single_en = 0;
    tick(5);

    // continuous, 9-bit, divider 0
    tag = "R7"; got.delete(); nine_bit = 1; divider = 8'd0;
    send(9'h1C3, 9); send(9'h05A, 9); send(9'h100, 9);
    cont_en = 1;
    wait_words(3, 400);
    cont_en = 0;
    check(got.size() == 3, "R7", "back-to-back words", got.size(), 3);
    check(got[0] == 9'h1C3 && got[1] == 9'h05A, "R5", "9-bit words", got[0], 9'h1C3);
    check(got[2] == 9'h100, "R5", "ninth bit", got[2], 9'h100);
    tick(1);
    check(sclk_out == 0, "R10", "idle after enables cleared", sclk_out, 0);
    tx_q.delete(); tick(5);

    // both enables, 8-bit, divider 1
    tag = "R8"; got.delete(); clr_cnt = 0; nine_bit = 0; divider = 8'd1;
    send(8'h3C, 8); send(8'hC3, 8);
    single_en = 1; cont_en = 1;
    wait_words(2, 400);
    tick(40);
    check(clr_cnt == 0, "R8", "no single_clr with both set", clr_cnt, 0);
    check(got.size() >= 3 && got[0] == 8'h3C && got[1] == 8'hC3, "R8", "continuous words", got[1], 8'hC3);
    single_en = 0; cont_en = 0;
    tx_q.delete(); tick(5);

    // buffer full at a word end
    tag = "R9"; got.delete();
    send(8'h11, 8); send(8'h22, 8); send(8'h33, 8);
    cont_en = 1;
    wait_words(1, 300);
    tick(20); push_ready = 0;
    tick(20); push_ready = 1;
    wait_words(2, 300);
    check(got.size() == 2 && got[0] == 8'h11 && got[1] == 8'h33, "R9", "word dropped when full",
          got.size() >= 2 ? got[1] : -1, 8'h33);
    cont_en = 0; tx_q.delete(); tick(5);

    // abort mid-word through port enable
    tag = "R10"; got.delete();
    send(8'hFF, 8);
    cont_en = 1;
    tick(12);
    port_en = 0;
    tick(1);
    check(sclk_out == 0, "R10", "sclk low after port disable", sclk_out, 0);
    tx_q.delete(); send(8'h5A, 8);
    port_en = 1;
    wait_words(1, 300);
    check(got.size() == 1 && got[0] == 8'h5A, "R10", "fresh word after abort", got.size() ? got[0] : -1, 8'h5A);
    cont_en = 0; port_en = 0;
    tick(5);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule